// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns a single active-low, asynchronous interrupt pin into a clean interrupt request for the CPU. The pin passes through a two-stage synchronizer. A falling transition seen on the synchronized level sets a pending request. A mode bit selects how the request behaves afterwards. In edge mode the request holds until it is cleared. In edge-plus-level mode it also stays pending while the pin is held low.

A request is cleared by a one-cycle acknowledge pulse from the CPU's vector fetch, by writing a one to the clear bit of a four-bit control/status register, or by reset. A mask bit hides the request from the CPU output without touching the stored state.

The core is a three-state machine. ST_IDLE means no request. ST_LATCHED means a request that is waiting for a clear. ST_HOLD means level mode only: the request has been cleared but is still pending because the pin is low. The transitions are:
- IDLE→LATCHED on a synchronized falling edge, or on mode=1 with the pin low.
- LATCHED→LATCHED on a new falling edge, even when a clear arrives in the same cycle.
- LATCHED→IDLE on a clear when mode=0 or the pin is high.
- LATCHED→HOLD on a clear when mode=1 and the pin is low.
- HOLD→IDLE when the pin goes high or mode is cleared.

Top module: `irq_latch_top`

## Requirements
- R1: Synchronous reset clears the request, the mode bit and the mask bit. Reads then return 0 and `irq_o` is low, even while the pin is held low.
- R2: A falling transition on `pin_n` sets the pending request. `irq_o` rises at the third rising clock edge after the pin falls, because of the two synchronizer stages plus the state register.
- R3: With mode=0, the request stays pending after the pin returns high, until a clear or reset.
- R4: An `ack_i` pulse clears a pending request at the next rising edge when mode=0.
- R5: A register write with bit 2 set clears the request. A write with bit 2 clear does not change the pending state.
- R6: With mode=1, a clear that arrives while the pin is low leaves the request pending. The request drops at the third rising edge after the pin returns high.
- R7: With mode=1, if the pin returns high before the clear, the request drops at the clear.
- R8: With mode=1, a low pin sets the request even without an edge. This applies when mode is written to 1 while the pin is low: the request is set one cycle after the write.
- R9: Mask bit 1 forces `irq_o` low while read bit 3 still shows the pending request. `irq_o` rises in the cycle after the mask is written to 0.
- R10: Register layout: bit 0 is the mode (read/write), bit 1 is the mask (read/write), bit 2 is the clear (write-only, always reads 0), and bit 3 is the pending flag before masking (read-only).
- R11: When a synchronized falling edge and a clear occur in the same cycle, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; hold for at least 3 cycles |
| pin_n | input | 1 | Raw asynchronous interrupt pin, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read value |
| ack_i | input | 1 | Interrupt acknowledge pulse from vector fetch |
| irq_o | output | 1 | Masked interrupt request to the CPU |

## Verification
The assertions assume that reset is held long enough to flush the unreset synchronizer chain. They also assume that the pin stays at each level for at least one clock, so that every synchronized edge is a real transition. The stimulus holds reset for five cycles and changes the pin only on falling clock edges. It spaces random operations five cycles apart, so that every synchronizer delay has settled before the next event. The only cycle-exact coincidence, a clear landing on the same edge as a detected fall, is built on purpose in a directed case.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LATCHED = 2'd1,
        ST_HOLD    = 2'd2
    } irq_state_e;

    localparam int BIT_MODE = 0;
    localparam int BIT_MASK = 1;
    localparam int BIT_CLR  = 2;
    localparam int BIT_PEND = 3;
    localparam int MIN_REG_W = 4;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_low,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    // Free-running chain; reset is intentionally not applied so that a pin
    // held low through reset is not seen as a fresh edge afterwards.
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[CHAIN_W-2:0], pin_n};
    end

    assign pin_low = ~chain[STAGES-1];
    assign fall    = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_latch_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pending,
    output logic             mode,
    output logic             mask,
    output logic             sw_clear,
    output logic [REG_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= 1'b0;
            mask <= 1'b0;
        end else if (wr_en) begin
            mode <= wr_data[BIT_MODE];
            mask <= wr_data[BIT_MASK];
        end
    end

    assign sw_clear = wr_en & wr_data[BIT_CLR];

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_MODE] = mode;
        rd_data[BIT_MASK] = mask;
        rd_data[BIT_PEND] = pending;
    end
endmodule

// File: rtl/irq_latch_fsm.sv
module irq_latch_fsm
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode,
    input  logic fall,
    input  logic pin_low,
    input  logic clear,
    output logic pending
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall || (mode && pin_low)) begin
                    state_d = ST_LATCHED;
                end
            end
            ST_LATCHED: begin
                // a new edge wins over a coincident clear
                if (!fall && clear) begin
                    state_d = (mode && pin_low) ? ST_HOLD : ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!mode || !pin_low) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/irq_latch_top.sv
module irq_latch_top
    import irq_latch_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ack_i,
    output logic             irq_o
);
    logic pin_low;
    logic fall;
    logic mode;
    logic mask;
    logic sw_clear;
    logic clear;
    logic pending;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .pin_n   (pin_n),
        .pin_low (pin_low),
        .fall    (fall)
    );

    irq_ctrl_reg #(.REG_W(REG_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pending  (pending),
        .mode     (mode),
        .mask     (mask),
        .sw_clear (sw_clear),
        .rd_data  (rd_data)
    );

    assign clear = ack_i | sw_clear;

    irq_latch_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .fall    (fall),
        .pin_low (pin_low),
        .clear   (clear),
        .pending (pending)
    );

    assign irq_o = pending & ~mask;
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
    import irq_latch_pkg::*;
#(
    parameter int REG_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             fall,
    input logic             pin_low,
    input logic             clear,
    input logic [REG_W-1:0] rd_data,
    input logic             irq_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!rd_data[BIT_PEND] && !rd_data[BIT_MODE] && !rd_data[BIT_MASK] && !irq_o));

    assert_fall_sets_R2: assert property (@(posedge clk) disable iff (rst)
        fall |=> rd_data[BIT_PEND]);

    assert_edge_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (clear && !fall && !rd_data[BIT_MODE]) |=> !rd_data[BIT_PEND]);

    assert_level_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_data[BIT_MODE] && pin_low && rd_data[BIT_PEND]) |=> rd_data[BIT_PEND]);

    assert_level_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_data[BIT_MODE] && pin_low && !rd_data[BIT_PEND]) |=> rd_data[BIT_PEND]);

    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        rd_data[BIT_MASK] |-> !irq_o);

    assert_clr_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_data[BIT_CLR]);

    assert_set_priority_R11: assert property (@(posedge clk) disable iff (rst)
        (fall && clear && rd_data[BIT_PEND]) |=> rd_data[BIT_PEND]);
endmodule

bind irq_latch_top irq_latch_chk #(.REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fall    (fall),
    .pin_low (pin_low),
    .clear   (clear),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/irq_latch_top_tb.sv
module irq_latch_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       ack_i = 1'b0;
    logic [3:0] rd_data;
    logic       irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    int  m_st   = 0;
    bit  m_mode = 1'b0;
    bit  m_mask = 1'b0;
    bit  m_pin  = 1'b1;

    always #10 clk = ~clk;

    irq_latch_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (pin_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ack_i   (ack_i),
        .irq_o   (irq_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step(1);
        wr_en = 1'b0;
        wr_data = 4'd0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
    endtask

    function automatic int clr_next(int st, bit mode, bit low);
        if (st == 1) return (mode && low) ? 2 : 0;
        return st;
    endfunction

    function automatic int settle(int st, bit mode, bit low);
        if (st == 0 && mode && low) return 1;
        if (st == 2 && (!mode || !low)) return 0;
        return st;
    endfunction

    function automatic logic [3:0] exp_rd(int st, bit mode, bit mask);
        return {(st != 0), 1'b0, mask, mode};
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset with pin held low
        step(5);
        rst = 1'b0;
        step(5);
        chk("R1 rd after reset, pin low", 8'(rd_data), 8'h0);
        chk("R1 irq after reset", 8'(irq_o), 8'h0);
        pin_n = 1'b1;
        step(4);

        // R2 + R10: latency and read layout
        pin_n = 1'b0;
        step(2);
        chk("R2 irq before third edge", 8'(irq_o), 8'h0);
        step(1);
        chk("R2 irq at third edge", 8'(irq_o), 8'h1);
        chk("R10 rd shows pending bit3", 8'(rd_data), 8'h8);

        // R3: edge mode keeps request after pin high
        pin_n = 1'b1;
        step(4);
        chk("R3 pending after pin high", 8'(rd_data[3]), 8'h1);

        // R4: ack clears
        pulse_ack();
        chk("R4 pending after ack", 8'(rd_data[3]), 8'h0);
        chk("R4 irq after ack", 8'(irq_o), 8'h0);

        // R5: write clear bit
        pin_n = 1'b0; step(3); pin_n = 1'b1; step(3);
        reg_write(4'b0000);
        chk("R5 write zero keeps pending", 8'(rd_data), 8'h8);
        reg_write(4'b0100);
        chk("R5 write clear bit", 8'(rd_data), 8'h0);

        // R6: level mode, clear while low
        reg_write(4'b0001);
        pin_n = 1'b0; step(3);
        chk("R6 pending in level mode", 8'(rd_data), 8'h9);
        pulse_ack();
        chk("R6 ack while low keeps pending", 8'(rd_data[3]), 8'h1);
        step(3);
        chk("R6 still pending pin low", 8'(rd_data[3]), 8'h1);
        pin_n = 1'b1;
        step(2);
        chk("R6 pending before sync rise", 8'(rd_data[3]), 8'h1);
        step(1);
        chk("R6 drops after pin high", 8'(rd_data[3]), 8'h0);

        // R7: level mode, pin high first then clear
        pin_n = 1'b0; step(3); pin_n = 1'b1; step(4);
        chk("R7 pending after pin high", 8'(rd_data[3]), 8'h1);
        pulse_ack();
        chk("R7 clear after pin high", 8'(rd_data[3]), 8'h0);

        // R8: writing mode=1 with pin low
        reg_write(4'b0000);
        pin_n = 1'b0; step(4);
        pulse_ack();
        step(2);
        chk("R8 idle in edge mode pin low", 8'(rd_data[3]), 8'h0);
        reg_write(4'b0001);
        chk("R8 not yet set at mode write", 8'(rd_data[3]), 8'h0);
        step(1);
        chk("R8 level sets request", 8'(rd_data[3]), 8'h1);
        pin_n = 1'b1; step(4);
        pulse_ack();
        reg_write(4'b0000);

        // R9: mask
        reg_write(4'b0010);
        pin_n = 1'b0; step(3);
        chk("R9 rd with mask", 8'(rd_data), 8'hA);
        chk("R9 irq masked", 8'(irq_o), 8'h0);
        reg_write(4'b0000);
        chk("R9 irq after unmask", 8'(irq_o), 8'h1);
        pin_n = 1'b1; step(4);
        pulse_ack();

        // R11: fall coincides with clear
        pin_n = 1'b0; step(3); pin_n = 1'b1; step(4);
        pin_n = 1'b0;
        step(2);
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
        chk("R11 set wins over clear", 8'(rd_data[3]), 8'h1);
        pulse_ack();
        chk("R4 clear after coincidence", 8'(rd_data[3]), 8'h0);
        pin_n = 1'b1; step(4);

        // R1: reset mid-operation with pin low
        reg_write(4'b0011);
        pin_n = 1'b0; step(4);
        rst = 1'b1; step(1); rst = 1'b0;
        step(3);
        chk("R1 reset clears mode and latch", 8'(rd_data), 8'h0);
        chk("R1 irq low after reset", 8'(irq_o), 8'h0);
        pin_n = 1'b1; step(4);

        // random phase against the bench model
        m_st = 0; m_mode = 1'b0; m_mask = 1'b0; m_pin = 1'b1;
        for (int i = 0; i < 60; i++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: begin
                    if (m_pin) begin
                        m_st = 1;
                        m_pin = 1'b0;
                    end else begin
                        m_pin = 1'b1;
                    end
                    pin_n = m_pin;
                    step(1);
                end
                1: begin
                    m_st = clr_next(m_st, m_mode, !m_pin);
                    pulse_ack();
                end
                2: begin
                    logic [3:0] d;
                    d = 4'($urandom);
                    if (d[2]) m_st = clr_next(m_st, m_mode, !m_pin);
                    m_mode = d[0];
                    m_mask = d[1];
                    reg_write(d);
                end
                default: begin
                    m_mask = ~m_mask;
                    reg_write({2'b00, m_mask, m_mode});
                end
            endcase
            m_st = settle(m_st, m_mode, !m_pin);
            step(5);
            chk("R2/R3/R5/R6/R8/R9 random rd", 8'(rd_data), 8'(exp_rd(m_st, m_mode, m_mask)));
            chk("R9 random irq", 8'(irq_o), 8'((m_st != 0) && !m_mask));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule